// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial line. It does not generate a baud clock. A one-cycle enable pulse, `tick16`, arrives at sixteen times the bit rate, and every timing decision counts these pulses. The line is synchronized first. A falling edge starts a frame. The start bit is confirmed at its midpoint, and every later bit is sampled sixteen ticks after the one before it.

The frame format is set at run time:
- 5 to 9 data bits.
- Parity that is none, even or odd.
- One or two stop bits.

Each finished character goes into a single holding register and raises a valid level. The consumer takes the character and pulses `rdAck`. Four sticky flags report line faults: parity error, framing error, overrun and break. They stay set until the same acknowledge.

Top module: `async_rx`

## Requirements
- R1: After reset, `rxValid` is 0 and all four error flags are 0.
- R2: Data bits are taken least-significant first, for `cfgDataBits` from 5 to 9. The word is presented right-justified on `rxData`, and every bit at or above `cfgDataBits` is 0.
- R3: A low pulse that has ended by the middle of the start bit (the 8th tick after detection) is treated as noise. It produces no word and no flag.
- R4: `cfgParity` selects the parity mode: 00 none, 01 even, 10 odd, 11 none.
  - Even mode: the data bits plus the parity bit must contain an even number of ones.
  - Odd mode: the data bits plus the parity bit must contain an odd number of ones.
  - A mismatch sets `errParity`, and the word is still stored.
- R5: Each stop bit is sampled: one stop bit when `cfgTwoStop`=0, two when it is 1. Any stop bit sampled low sets `errFrame`, and the word is still stored.
- R6: When a word completes while `rxValid` is 1 and no acknowledge is given, `errOverrun` is set. The older word stays on `rxData` and the new word is dropped.
- R7: A frame in which every sample from the start bit through the last stop bit is low is a break.
  - A break sets `errBreak`, stores no word and does not set `errFrame`.
  - The receiver does not look for a new start bit until the line has returned high.
- R8: An `rdAck` pulse clears `rxValid` and all four error flags.
- R9: The error flags are sticky: once set, each stays set until `rdAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxLine | input | 1 | Serial line, idle high |
| cfgDataBits | input | 4 | Number of data bits, 5 to 9 |
| cfgParity | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| rdAck | input | 1 | Consumer acknowledge; frees the holding register and clears the flags |
| rxData | output | 9 | Held word, right-justified |
| rxValid | output | 1 | Holding register contains an unread word |
| errParity | output | 1 | Sticky parity error |
| errFrame | output | 1 | Sticky framing error |
| errOverrun | output | 1 | Sticky overrun |
| errBreak | output | 1 | Sticky break |

## Verification
The properties assume two things about the inputs:
- `cfgDataBits` stays within 5 to 9.
- The configuration does not change while a frame is in progress, because the upper-bit check reads the current `cfgDataBits`.

The stimulus respects both. It changes the format only when the line has been idle for at least one bit time, and it uses only legal bit counts. The bench also drives `tick16` at a steady one pulse every two clocks. This keeps the sampling point of every bit well inside the bit time the bench holds on the line.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_FINISH,
    ST_WAITHI
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearFrame;
    logic sampleData;
    logic sampleParity;
    logic sampleStop;
    logic finish;
  } rxStrobe_t;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/async_rx_ctl.sv
module async_rx_ctl
  import async_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick16,
  input  logic                          lineS,
  input  logic [$clog2(DATA_MAX+1)-1:0] cfgDataBits,
  input  logic                          parityOn,
  input  logic                          cfgTwoStop,
  input  logic                          lineBreak,
  output rxStrobe_t                     strobe
);

  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DATA_MAX + 1);
  localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  rxState_t      st, stNext;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitCnt;
  logic          restartTick;
  logic          onSample;

  assign onSample = tick16 && (tickCnt == LAST);

  always_comb begin
    stNext      = st;
    strobe      = '0;
    restartTick = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (tick16 && !lineS) begin
          stNext            = ST_START;
          strobe.clearFrame = 1'b1;
          restartTick       = 1'b1;
        end
      end
      ST_START: begin
        if (tick16 && tickCnt == MID) begin
          restartTick = 1'b1;
          stNext      = lineS ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (onSample) begin
          strobe.sampleData = 1'b1;
          if (bitCnt == cfgDataBits - BW'(1))
            stNext = parityOn ? ST_PARITY : ST_STOP;
        end
      end
      ST_PARITY: begin
        if (onSample) begin
          strobe.sampleParity = 1'b1;
          stNext              = ST_STOP;
        end
      end
      ST_STOP: begin
        if (onSample) begin
          strobe.sampleStop = 1'b1;
          if (!cfgTwoStop || bitCnt != '0) stNext = ST_FINISH;
        end
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stNext        = lineBreak ? ST_WAITHI : ST_IDLE;
      end
      ST_WAITHI: begin
        if (lineS) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      st <= stNext;
      if (restartTick)  tickCnt <= '0;
      else if (tick16)  tickCnt <= tickCnt + TW'(1);
      if (stNext != st) bitCnt <= '0;
      else if (strobe.sampleData || strobe.sampleStop) bitCnt <= bitCnt + BW'(1);
    end
  end

endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rxLine,
  input  rxStrobe_t                     strobe,
  input  logic [$clog2(DATA_MAX+1)-1:0] cfgDataBits,
  input  logic [1:0]                    cfgParity,
  input  logic                          rdAck,
  output logic                          lineS,
  output logic                          lineBreak,
  output logic [DATA_MAX-1:0]           rxData,
  output logic                          rxValid,
  output logic                          errParity,
  output logic                          errFrame,
  output logic                          errOverrun,
  output logic                          errBreak
);

  localparam int BW = $clog2(DATA_MAX + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_MAX-1:0]    shiftReg;
  logic [DATA_MAX-1:0]    word;
  logic [BW-1:0]          shiftAmt;
  logic parAcc, parBit, stopLow, allLow;
  logic parityOn, parBad, slotFree;

  // Synchronizer: the line is sampled only after SYNC_STAGES flops
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncReg <= '1;
        else       syncReg <= rxLine;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
    end
  endgenerate
  assign lineS = syncReg[SYNC_STAGES-1];

  // Frame assembly: each new bit enters at the top, so after N bits
  // the word sits in the upper N positions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      stopLow  <= 1'b0;
      allLow   <= 1'b0;
    end else if (strobe.clearFrame) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      stopLow  <= 1'b0;
      allLow   <= 1'b1;
    end else begin
      if (strobe.sampleData) begin
        shiftReg <= {lineS, shiftReg[DATA_MAX-1:1]};
        parAcc   <= parAcc ^ lineS;
      end
      if (strobe.sampleParity) parBit  <= lineS;
      if (strobe.sampleStop)   stopLow <= stopLow | ~lineS;
      if (strobe.sampleData || strobe.sampleParity || strobe.sampleStop)
        allLow <= allLow & ~lineS;
    end
  end

  assign lineBreak = allLow;
  assign shiftAmt  = BW'(DATA_MAX) - cfgDataBits;
  assign word      = shiftReg >> shiftAmt;
  assign parityOn  = (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);
  assign parBad    = parityOn && (parAcc ^ parBit ^ (cfgParity == PAR_ODD));
  assign slotFree  = !rxValid || rdAck;

  // Holding register and sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      errParity  <= 1'b0;
      errFrame   <= 1'b0;
      errOverrun <= 1'b0;
      errBreak   <= 1'b0;
    end else begin
      if (rdAck) begin
        rxValid    <= 1'b0;
        errParity  <= 1'b0;
        errFrame   <= 1'b0;
        errOverrun <= 1'b0;
        errBreak   <= 1'b0;
      end
      if (strobe.finish) begin
        if (allLow) begin
          errBreak <= 1'b1;
        end else begin
          if (stopLow) errFrame  <= 1'b1;
          if (parBad)  errParity <= 1'b1;
          if (slotFree) begin
            rxData  <= word;
            rxValid <= 1'b1;
          end else begin
            errOverrun <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick16,
  input  logic                          rxLine,
  input  logic [$clog2(DATA_MAX+1)-1:0] cfgDataBits,
  input  logic [1:0]                    cfgParity,
  input  logic                          cfgTwoStop,
  input  logic                          rdAck,
  output logic [DATA_MAX-1:0]           rxData,
  output logic                          rxValid,
  output logic                          errParity,
  output logic                          errFrame,
  output logic                          errOverrun,
  output logic                          errBreak
);

  rxStrobe_t strobe;
  logic      lineS, lineBreak, parityOn;

  assign parityOn = (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);

  async_rx_ctl #(.OVS(OVS), .DATA_MAX(DATA_MAX)) u_ctl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .lineS(lineS),
    .cfgDataBits(cfgDataBits), .parityOn(parityOn), .cfgTwoStop(cfgTwoStop),
    .lineBreak(lineBreak), .strobe(strobe)
  );

  async_rx_dp #(.DATA_MAX(DATA_MAX), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobe(strobe),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity), .rdAck(rdAck),
    .lineS(lineS), .lineBreak(lineBreak), .rxData(rxData), .rxValid(rxValid),
    .errParity(errParity), .errFrame(errFrame), .errOverrun(errOverrun),
    .errBreak(errBreak)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_MAX = 9
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [$clog2(DATA_MAX+1)-1:0] cfgDataBits,
  input logic                          rdAck,
  input logic [DATA_MAX-1:0]           rxData,
  input logic                          rxValid,
  input logic                          errParity,
  input logic                          errFrame,
  input logic                          errOverrun,
  input logic                          errBreak
);

  logic [3:0] flags;
  assign flags = {errParity, errFrame, errOverrun, errBreak};

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> cfgDataBits) == '0));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdAck) |=> (rxValid && $stable(rxData)));

  p_ovr_needs_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOverrun) |-> $past(rxValid));

  p_break_no_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBreak) |-> ($stable(rxData) && !$rose(rxValid)));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |=> !errOverrun);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdAck |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind async_rx async_rx_chk #(.DATA_MAX(DATA_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .cfgDataBits(cfgDataBits), .rdAck(rdAck),
  .rxData(rxData), .rxValid(rxValid), .errParity(errParity),
  .errFrame(errFrame), .errOverrun(errOverrun), .errBreak(errBreak)
);

// File: tb/async_rx_test.sv
`timescale 1ns/1ps
module async_rx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxLine = 1'b1;
  logic [3:0] cfgDataBits = 4'd8;
  logic [1:0] cfgParity = 2'b00;
  logic       cfgTwoStop = 1'b0;
  logic       rdAck = 1'b0;
  logic [8:0] rxData;
  logic       rxValid, errParity, errFrame, errOverrun, errBreak;

  int checks = 0;
  int errors = 0;

  async_rx uut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop),
    .rdAck(rdAck), .rxData(rxData), .rxValid(rxValid), .errParity(errParity),
    .errFrame(errFrame), .errOverrun(errOverrun), .errBreak(errBreak)
  );

  always #2.5 clk = ~clk;

  // One tick every two clocks: a bit lasts 32 clocks
  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic bitTime();
    repeat (32) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk) rdAck = 1'b1;
    @(negedge clk) rdAck = 1'b0;
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic flipPar,
                           input logic stop0, input logic stop1);
    logic p;
    p = 1'b0;
    @(negedge clk) rxLine = 1'b0;
    bitTime();
    for (int i = 0; i < int'(cfgDataBits); i++) begin
      rxLine = d[i];
      p = p ^ d[i];
      bitTime();
    end
    if (cfgParity == 2'b01 || cfgParity == 2'b10) begin
      rxLine = p ^ (cfgParity == 2'b10) ^ flipPar;
      bitTime();
    end
    rxLine = stop0;
    bitTime();
    if (cfgTwoStop) begin
      rxLine = stop1;
      bitTime();
    end
    rxLine = 1'b1;
    bitTime();
  endtask

  task automatic testReset();
    check("R1 valid", rxValid, 0);
    check("R1 flags", {errParity, errFrame, errOverrun, errBreak}, 0);
  endtask

  task automatic testBasic();
    cfgDataBits = 4'd8; cfgParity = 2'b00; cfgTwoStop = 1'b0;
    sendFrame(9'h0A5, 1'b0, 1'b1, 1'b1);
    check("R2 valid 8N1", rxValid, 1);
    check("R2 data 8N1", rxData, 9'h0A5);
    check("R2 no flags", {errParity, errFrame, errOverrun, errBreak}, 0);
    ack();
    check("R8 valid cleared", rxValid, 0);
    cfgDataBits = 4'd5;
    sendFrame(9'h013, 1'b0, 1'b1, 1'b1);
    check("R2 data 5 bits", rxData, 9'h013);
    ack();
    cfgDataBits = 4'd9; cfgTwoStop = 1'b1;
    sendFrame(9'h1A5, 1'b0, 1'b1, 1'b1);
    check("R2 data 9 bits two stop", rxData, 9'h1A5);
    check("R5 clean two stop", errFrame, 0);
    ack();
  endtask

  task automatic testGlitch();
    cfgDataBits = 4'd8; cfgParity = 2'b00; cfgTwoStop = 1'b0;
    @(negedge clk) rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    repeat (12) bitTime();
    check("R3 glitch no word", rxValid, 0);
    check("R3 glitch no flags", {errParity, errFrame, errOverrun, errBreak}, 0);
  endtask

  task automatic testParity();
    cfgDataBits = 4'd8; cfgParity = 2'b01;
    sendFrame(9'h0C3, 1'b0, 1'b1, 1'b1);
    check("R4 even good", errParity, 0);
    check("R4 even data", rxData, 9'h0C3);
    ack();
    sendFrame(9'h0C3, 1'b1, 1'b1, 1'b1);
    check("R4 even bad flag", errParity, 1);
    check("R4 bad word kept", rxData, 9'h0C3);
    ack();
    cfgParity = 2'b10;
    sendFrame(9'h071, 1'b0, 1'b1, 1'b1);
    check("R4 odd good", errParity, 0);
    ack();
    sendFrame(9'h071, 1'b1, 1'b1, 1'b1);
    check("R4 odd bad flag", errParity, 1);
    ack();
    cfgParity = 2'b00;
  endtask

  task automatic testFraming();
    cfgDataBits = 4'd8; cfgTwoStop = 1'b0;
    sendFrame(9'h0A5, 1'b0, 1'b0, 1'b1);
    check("R5 stop low flag", errFrame, 1);
    check("R5 word stored", rxValid, 1);
    check("R5 word value", rxData, 9'h0A5);
    repeat (10) bitTime();
    check("R9 frame flag sticky", errFrame, 1);
    ack();
    check("R8 frame flag cleared", errFrame, 0);
    cfgTwoStop = 1'b1;
    sendFrame(9'h03C, 1'b0, 1'b1, 1'b0);
    check("R5 second stop low", errFrame, 1);
    ack();
    cfgTwoStop = 1'b0;
  endtask

  task automatic testOverrun();
    cfgDataBits = 4'd8;
    sendFrame(9'h011, 1'b0, 1'b1, 1'b1);
    sendFrame(9'h022, 1'b0, 1'b1, 1'b1);
    check("R6 overrun flag", errOverrun, 1);
    check("R6 older word kept", rxData, 9'h011);
    ack();
    check("R8 overrun cleared", errOverrun, 0);
    check("R8 valid cleared", rxValid, 0);
  endtask

  task automatic testBreak();
    cfgDataBits = 4'd8; cfgParity = 2'b00; cfgTwoStop = 1'b0;
    @(negedge clk) rxLine = 1'b0;
    repeat (12) bitTime();
    check("R7 break flag", errBreak, 1);
    check("R7 no word", rxValid, 0);
    check("R7 no framing", errFrame, 0);
    ack();
    repeat (24) bitTime();
    check("R7 no rearm while low", errBreak, 0);
    rxLine = 1'b1;
    bitTime();
    sendFrame(9'h05A, 1'b0, 1'b1, 1'b1);
    check("R7 rearmed data", rxData, 9'h05A);
    check("R7 rearmed valid", rxValid, 1);
    ack();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testBasic();
    testGlitch();
    testParity();
    testFraming();
    testOverrun();
    testBreak();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule